// File: doc/BRIEF.md
# Staggered Quad PWM Generator

This block turns four 4-bit duty codes into four pulse-width-modulated drive signals that share one period. The period is cut into 16 equal slots, and a slot lasts two rising edges of an oscillator input, so one full period spans 32 oscillator rising edges. The oscillator input is asynchronous to the system clock. It is brought in through a synchronizer, and only its rising edges advance the slot count.

Channels with an even index start their pulse at the first slot of the period. Channels with an odd index end their pulse at the last slot. Because of this offset, the two groups do not switch their edges together. Every channel also produces a gated drive signal. An overcurrent flag blanks that signal until the current period ends, and a global undervoltage flag holds every drive signal low. Neither flag changes the programmed duty codes or the slot position.

A controller writes the codes on `duty_i` whenever it likes. Each channel picks up its new code only at the next period boundary.

Top module: `qpwm_top`

## Requirements
- R1: After reset, every raw and every drive output is low.
- R2: Channel i takes its code k from duty_i[4i+3:4i]. For k from 1 to 15, its raw output is high for exactly k of the 16 slots in each period.
- R3: A code of zero keeps that channel's raw and drive outputs low for the whole period.
- R4: A slot lasts two rising edges of the synchronized oscillator, and a period is 16 slots, which is 32 oscillator rising edges.
- R5: Channels 0 and 2 go high at the start of slot 0. Channels 1 and 3 go low at the start of slot 0 and are high during the last k slots of the period.
- R6: A code written on duty_i takes effect only at the next period boundary. A period already running keeps its old pulse width.
- R7: In the cycle after a channel's overcurrent flag is sampled high, that channel's drive goes low and stays low for the rest of the period. Its raw output and the other channels are not affected.
- R8: The overcurrent cut-off clears at the period boundary, so drive follows raw again in the next period unless the flag is still high.
- R9: In the cycle after the undervoltage flag is sampled high, all drive outputs are low, and they stay low while the flag is high. Raw outputs, codes and slot position keep running, and drive resumes without any new code being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_i | input | 1 | Asynchronous oscillator that sets the PWM time base |
| duty_i | input | 16 | Four duty codes, channel i in bits [4i+3:4i] |
| oc_i | input | 4 | Overcurrent flag for each channel |
| uv_i | input | 1 | Supply undervoltage flag |
| raw_o | output | 4 | Ungated PWM signal for each channel |
| drive_o | output | 4 | PWM after overcurrent and undervoltage gating |

## Verification
The bench changes a code in the middle of a period. A design without shadowed codes would stretch the pulse that is already running, giving 96 high cycles where 24 are expected. It measures the extreme codes 1, 15 and 0. An off-by-one in the head or tail compare would add or drop a slot there, or would let code 0 light a tail channel for a full period. It pulses overcurrent during a tail pulse and checks two things: the rest of that pulse stays dark, and the next period lights again. A latch that never clears would keep the channel dark forever. It also raises undervoltage across several periods. A design that reset its codes on undervoltage would come back with all outputs silent.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;

    // Which end of the period a channel's pulse is anchored to.
    typedef enum logic {
        ALIGN_HEAD = 1'b0,
        ALIGN_TAIL = 1'b1
    } align_e;

    // Even channels lead the period, odd channels trail it.
    function automatic align_e align_of(input int idx);
        return (idx % 2 == 0) ? ALIGN_HEAD : ALIGN_TAIL;
    endfunction

endpackage

// File: rtl/qpwm_osc_tick.sv
module qpwm_osc_tick #(
    parameter int SYNC_STAGES  = 2,
    parameter int OSC_PER_SLOT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_i,
    output logic tick_o
);
    localparam int DIV_W = (OSC_PER_SLOT > 1) ? $clog2(OSC_PER_SLOT) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(OSC_PER_SLOT - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [DIV_W-1:0]       div;
    } st_t;

    st_t  s_q, s_d;
    logic rise;

    always_comb begin
        s_d      = s_q;
        tick_o   = 1'b0;
        s_d.sync = (s_q.sync << 1) | SYNC_STAGES'(osc_i);
        s_d.prev = s_q.sync[SYNC_STAGES-1];
        rise     = s_q.sync[SYNC_STAGES-1] & ~s_q.prev;
        if (rise) begin
            if (s_q.div == DIV_LAST) begin
                s_d.div = '0;
                tick_o  = 1'b1;
            end else begin
                s_d.div = s_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/qpwm_slot_ctr.sv
module qpwm_slot_ctr #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    output logic [CODE_W-1:0] slot_o,
    output logic              wrap_o
);
    localparam logic [CODE_W-1:0] SLOT_LAST = '1;

    typedef struct packed {
        logic [CODE_W-1:0] slot;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d    = s_q;
        wrap_o = tick_i && (s_q.slot == SLOT_LAST);
        if (tick_i) s_d.slot = s_q.slot + 1'b1;
        slot_o = s_q.slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/qpwm_channel.sv
module qpwm_channel #(
    parameter int              CODE_W = 4,
    parameter qpwm_pkg::align_e ALIGN = qpwm_pkg::ALIGN_HEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap_i,
    input  logic [CODE_W-1:0] slot_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              oc_i,
    input  logic              uv_i,
    output logic              raw_o,
    output logic              drive_o,
    output logic [CODE_W-1:0] code_o
);
    localparam int SLOTS = 1 << CODE_W;
    localparam logic [CODE_W:0] SLOTS_V = (CODE_W + 1)'(SLOTS);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              cut;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (wrap_i) begin
            s_d.code = code_i;
            s_d.cut  = oc_i;
        end else begin
            s_d.cut  = s_q.cut | oc_i;
        end
    end

    generate
        if (ALIGN == qpwm_pkg::ALIGN_HEAD) begin : g_head
            assign raw_o = (slot_i < s_q.code);
        end else begin : g_tail
            assign raw_o = ({1'b0, slot_i} >= (SLOTS_V - {1'b0, s_q.code}));
        end
    endgenerate

    assign drive_o = raw_o & ~s_q.cut & ~uv_i;
    assign code_o  = s_q.code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/qpwm_top.sv
module qpwm_top #(
    parameter int NCH          = 4,
    parameter int CODE_W       = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int OSC_PER_SLOT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  osc_i,
    input  logic [NCH*CODE_W-1:0] duty_i,
    input  logic [NCH-1:0]        oc_i,
    input  logic                  uv_i,
    output logic [NCH-1:0]        raw_o,
    output logic [NCH-1:0]        drive_o
);
    typedef struct packed {
        logic uv;
    } top_st_t;

    top_st_t               t_q, t_d;
    logic                  slot_tick;
    logic                  period_wrap;
    logic [CODE_W-1:0]     slot_cnt;
    logic [NCH*CODE_W-1:0] code_act;

    always_comb begin
        t_d    = t_q;
        t_d.uv = uv_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    qpwm_osc_tick #(
        .SYNC_STAGES (SYNC_STAGES),
        .OSC_PER_SLOT(OSC_PER_SLOT)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .osc_i (osc_i),
        .tick_o(slot_tick)
    );

    qpwm_slot_ctr #(
        .CODE_W(CODE_W)
    ) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(slot_tick),
        .slot_o(slot_cnt),
        .wrap_o(period_wrap)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            qpwm_channel #(
                .CODE_W(CODE_W),
                .ALIGN (qpwm_pkg::align_of(g))
            ) u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .wrap_i (period_wrap),
                .slot_i (slot_cnt),
                .code_i (duty_i[g*CODE_W +: CODE_W]),
                .oc_i   (oc_i[g]),
                .uv_i   (t_q.uv),
                .raw_o  (raw_o[g]),
                .drive_o(drive_o[g]),
                .code_o (code_act[g*CODE_W +: CODE_W])
            );
        end
    endgenerate
endmodule

// File: rtl/qpwm_chk.sv
module qpwm_chk #(
    parameter int NCH    = 4,
    parameter int CODE_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_i,
    input logic                  wrap_i,
    input logic [CODE_W-1:0]     slot_i,
    input logic [NCH*CODE_W-1:0] code_i,
    input logic [NCH-1:0]        oc_i,
    input logic                  uv_i,
    input logic [NCH-1:0]        raw_i,
    input logic [NCH-1:0]        drive_i
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (raw_i == '0 && drive_i == '0));

    assert_slot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(slot_i));

    assert_slot_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (slot_i == CODE_W'($past(slot_i) + 1'b1)));

    assert_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(code_i));

    assert_uv_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |=> (drive_i == '0));

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chk
            assert_oc_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
                oc_i[g] |=> !drive_i[g]);

            assert_drive_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
                drive_i[g] |-> raw_i[g]);

            assert_zero_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (code_i[g*CODE_W +: CODE_W] == '0) |-> !raw_i[g]);

            assert_cut_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (wrap_i && !oc_i[g] && !uv_i) |=> (drive_i[g] == raw_i[g]));
        end
    endgenerate
endmodule

bind qpwm_top qpwm_chk #(
    .NCH   (NCH),
    .CODE_W(CODE_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (slot_tick),
    .wrap_i (period_wrap),
    .slot_i (slot_cnt),
    .code_i (code_act),
    .oc_i   (oc_i),
    .uv_i   (uv_i),
    .raw_i  (raw_o),
    .drive_i(drive_o)
);

// File: tb/qpwm_top_tb.sv
`timescale 1ns/1ps
module qpwm_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc = 1'b0;
    logic [15:0] duty = '0;
    logic [3:0]  oc = '0;
    logic        uv = 1'b0;
    logic [3:0]  raw_o, drive_o;

    int    n_checks = 0;
    int    n_err = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_slot, m_div;
    bit m_s0, m_s1, m_prev, m_uv, m_rise, m_tick, m_wrap;
    int m_code [4];
    bit m_cut  [4];

    always #4 clk = ~clk;

    qpwm_top u_dut (
        .clk(clk), .rst_n(rst_n), .osc_i(osc), .duty_i(duty),
        .oc_i(oc), .uv_i(uv), .raw_o(raw_o), .drive_o(drive_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_raw(input int ch);
        if (ch % 2 == 0) return m_slot < m_code[ch];
        return m_slot >= 16 - m_code[ch];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_slot = 0; m_div = 0; m_s0 = 0; m_s1 = 0; m_prev = 0; m_uv = 0;
            for (int c = 0; c < 4; c++) begin m_code[c] = 0; m_cut[c] = 0; end
        end else begin
            m_rise = m_s1 && !m_prev;
            m_tick = 0;
            if (m_rise) begin
                if (m_div == 1) begin m_div = 0; m_tick = 1; end
                else m_div = m_div + 1;
            end
            m_wrap = m_tick && (m_slot == 15);
            for (int c = 0; c < 4; c++) begin
                if (m_wrap) begin
                    m_code[c] = int'(duty[4*c +: 4]);
                    m_cut[c]  = oc[c];
                end else begin
                    m_cut[c]  = m_cut[c] | oc[c];
                end
            end
            if (m_tick) m_slot = (m_slot + 1) % 16;
            m_uv = uv; m_prev = m_s1; m_s1 = m_s0; m_s0 = osc;
        end
    end

    // compare every cycle against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < 4; c++) begin
                chk(raw_o[c] == m_raw(c), {cur_req, " raw"}, int'(raw_o[c]), int'(m_raw(c)));
                chk(drive_o[c] == (m_raw(c) && !m_cut[c] && !m_uv), {cur_req, " drive"},
                    int'(drive_o[c]), int'(m_raw(c) && !m_cut[c] && !m_uv));
            end
        end
    end

    initial begin
        forever begin
            repeat (2) @(negedge clk);
            osc = ~osc;
        end
    end

    task automatic wait_rise(input int ch);
        bit p;
        @(negedge clk); p = raw_o[ch];
        forever begin
            @(negedge clk);
            if (raw_o[ch] && !p) break;
            p = raw_o[ch];
        end
    endtask

    // rise-to-rise period length and high time, in clock cycles (one slot = 8)
    task automatic measure(input int ch, input int k);
        int hi = 0, len = 0;
        bit p;
        wait_rise(ch);
        forever begin
            hi += int'(raw_o[ch]); len++;
            p = raw_o[ch];
            @(negedge clk);
            if (raw_o[ch] && !p) break;
        end
        chk(len == 128, "R4 period", len, 128);
        chk(hi == 8 * k, "R2 high time", hi, 8 * k);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cnt, cnt2;
        bit p1, p2, p3;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(raw_o == 4'b0, "R1 raw after reset", int'(raw_o), 0);
        chk(drive_o == 4'b0, "R1 drive after reset", int'(drive_o), 0);

        cur_req = "R3";
        cnt = 0;
        repeat (200) begin @(negedge clk); cnt += $countones(raw_o); end
        chk(cnt == 0, "R3 all codes zero", cnt, 0);

        cur_req = "R2";
        duty = {4'd1, 4'd15, 4'd5, 4'd3};
        repeat (300) @(negedge clk);
        measure(0, 3);
        measure(1, 5);
        measure(2, 15);
        measure(3, 1);

        cur_req = "R5";
        @(negedge clk);
        p1 = raw_o[1]; p2 = raw_o[2]; p3 = raw_o[3];
        forever begin
            @(negedge clk);
            if (raw_o[0] && !p2 && raw_o[2]) break;
            p1 = raw_o[1]; p2 = raw_o[2]; p3 = raw_o[3];
        end
        chk(p1 && !raw_o[1], "R5 tail ch1 falls at head rise", int'(raw_o[1]), 0);
        chk(p3 && !raw_o[3], "R5 tail ch3 falls at head rise", int'(raw_o[3]), 0);

        cur_req = "R6";
        wait_rise(0);
        duty[3:0] = 4'd12;
        cnt = 0;
        while (raw_o[0]) begin cnt++; @(negedge clk); end
        chk(cnt == 24, "R6 running period keeps old code", cnt, 24);
        measure(0, 12);

        cur_req = "R7";
        wait_rise(1);
        oc[1] = 1'b1;
        @(negedge clk);
        oc[1] = 1'b0;
        cnt = 0; cnt2 = 0;
        while (raw_o[1]) begin
            cnt += int'(drive_o[1]); cnt2++;
            @(negedge clk);
        end
        chk(cnt == 0, "R7 drive dark after overcurrent", cnt, 0);
        chk(cnt2 > 0, "R7 raw keeps running", cnt2, 1);
        cur_req = "R8";
        wait_rise(1);
        chk(drive_o[1] == 1'b1, "R8 drive back next period", int'(drive_o[1]), 1);

        cur_req = "R9";
        uv = 1'b1;
        @(negedge clk);
        cnt = 0; cnt2 = 0;
        repeat (300) begin
            @(negedge clk);
            cnt += $countones(drive_o); cnt2 += $countones(raw_o);
        end
        chk(cnt == 0, "R9 drives held low", cnt, 0);
        chk(cnt2 > 0, "R9 raw keeps running", cnt2, 1);
        uv = 1'b0;
        repeat (140) @(negedge clk);
        cnt = 0;
        repeat (128) begin @(negedge clk); cnt += int'(drive_o[0]); end
        chk(cnt == 96, "R9 code kept through undervoltage", cnt, 96);

        cur_req = "R3";
        duty[11:8] = 4'd0;
        repeat (300) @(negedge clk);
        cnt = 0;
        repeat (128) begin @(negedge clk); cnt += int'(raw_o[2]) + int'(drive_o[2]); end
        chk(cnt == 0, "R3 code zero keeps channel off", cnt, 0);

        finish_run();
    end
endmodule